// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port Controller

This block is one I/O port of sixteen pins, set up and operated over a simple 32-bit register bus. The bus has a word address, a write strobe, write data and combinational read data. Software gives each pin its own behaviour through five per-pin settings:

- a 2-bit function selector (input, general output, peripheral, analog);
- an output style bit (push-pull or open-drain);
- a 2-bit edge-rate code;
- a 2-bit resistor selector;
- a 4-bit peripheral lane selector.

Pin levels are driven through a data register. That register is written in full, or updated a bit at a time through a write-only set/clear word. Pad levels come back through a two-flop synchronizer and a read-only level register.

At the pad side the block gives each pin an output value, an output enable, and pull-up and pull-down enables. When a pin is in peripheral mode, its output value comes from one of sixteen peripheral lanes. Each lane is a 16-bit vector with one bit per pin. The edge-rate code is only stored and passed out to the pad ring.

Top module: `pinbank_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads 0. Every pin then has pad_oe=0, pad_pu=0 and pad_pd=0, which makes it a floating input.
- R2: The function code of pin p sits at bits [2p+1:2p] of the function register (word 0). In code 01 (general output) with push-pull style, pad_oe[p]=1 and pad_out[p] follows bit p of the output data register. In code 00 (input), pad_oe[p]=0.
- R3: Bit p of the style register (word 1) selects open-drain when it is 1. In a driving mode, an open-drain pin has pad_out[p]=0 and pad_oe[p] equal to the inverse of the pin's value, so a 1 is released and a 0 is pulled low.
- R4: In code 10 (peripheral), the pin drives af_lanes[s*16+p]. Here s is the pin's 4-bit selector. For pins 0-7, s sits at bits [4p+3:4p] of word 7. For pins 8-15, it sits at bits [4(p-8)+3:4(p-8)] of word 8. Lanes that are not selected have no effect on the pin.
- R5: In code 11 (analog), the pin has no drive and no pull enables, whatever its other settings, and its bit in the input level register reads 0.
- R6: The resistor code of pin p sits at bits [2p+1:2p] of word 3. Code 01 sets pad_pu[p]=1, code 10 sets pad_pd[p]=1, and codes 00 and 11 set neither.
- R7: The input level register (word 4, bits 15:0) shows each pin's pad level as it was two clock edges earlier. A change is not visible after a single edge.
- R8: A write to word 5 replaces the output data register with bits 15:0. The change is visible on the pins from the next cycle.
- R9: A write to word 6 sets output data bits where bits 15:0 are 1 and clears them where bits 31:16 are 1, in the same cycle. Bits with neither flag keep their value.
- R10: When both the set flag and the clear flag of a bit are 1 in one word-6 write, the bit ends up 1.
- R11: Word 6 always reads 0. Words 9-15 read 0, and writes to them change no register.
- R12: The edge-rate code of pin p sits at bits [2p+1:2p] of word 2. It reads back unchanged and appears on pad_speed[2p+1:2p].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from reg_addr) |
| pad_in | input | 16 | Raw pad levels |
| af_lanes | input | 256 | Peripheral lanes, bit s*16+p for lane s and pin p |
| pad_out | output | 16 | Output value per pin |
| pad_oe | output | 16 | Output enable per pin |
| pad_pu | output | 16 | Pull-up enable per pin |
| pad_pd | output | 16 | Pull-down enable per pin |
| pad_speed | output | 32 | Stored edge-rate code, 2 bits per pin |

## Verification
The bench goes after several corner cases, each of which a faulty design would get wrong in a visible way:

- **Set and clear in one write.** A design that favours the clear flag, or that rewrites untouched bits, would show a wrong output data readback.
- **Peripheral selection across pin halves.** A design that decodes the upper selector register for the wrong pin field would route the wrong lane, or would react to an unselected lane.
- **Analog mode.** A design that lets analog mode keep pulls or input levels would assert a pull enable or return a 1 from the level register.
- **Input synchronizer timing.** The bench samples the level register after one edge and after two. Too few stages would show the new level one edge early.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int NUM_PINS   = 16;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 4;
    localparam int SEL_W      = 4;
    localparam int NUM_LANES  = 1 << SEL_W;
    localparam int FIELD2_W   = 2 * NUM_PINS;
    localparam int HALF_PINS  = NUM_PINS / 2;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        FN_INPUT  = 2'b00,
        FN_OUTPUT = 2'b01,
        FN_PERIPH = 2'b10,
        FN_ANALOG = 2'b11
    } pin_fn_e;

    typedef enum logic [1:0] {
        RES_NONE = 2'b00,
        RES_UP   = 2'b01,
        RES_DOWN = 2'b10,
        RES_RSVD = 2'b11
    } res_sel_e;

    typedef enum logic [ADDR_W-1:0] {
        W_FUNC   = 4'd0,
        W_STYLE  = 4'd1,
        W_RATE   = 4'd2,
        W_RES    = 4'd3,
        W_LEVEL  = 4'd4,
        W_DATA   = 4'd5,
        W_SETCLR = 4'd6,
        W_SEL_LO = 4'd7,
        W_SEL_HI = 4'd8
    } word_e;

    typedef struct packed {
        pin_fn_e          fn;
        logic             open_drain;
        logic [1:0]       rate;
        res_sel_e         res;
        logic [SEL_W-1:0] lane_sel;
    } pin_cfg_t;

    typedef struct packed {
        logic value;
        logic enable;
        logic up;
        logic down;
    } pad_drive_t;

    function automatic logic fn_drives(input pin_fn_e fn);
        return (fn == FN_OUTPUT) || (fn == FN_PERIPH);
    endfunction

    function automatic logic [NUM_PINS-1:0] apply_setclr(
        input logic [NUM_PINS-1:0] cur,
        input logic [BUS_W-1:0]    word
    );
        logic [NUM_PINS-1:0] set_m;
        logic [NUM_PINS-1:0] clr_m;
        set_m = word[NUM_PINS-1:0];
        clr_m = word[2*NUM_PINS-1:NUM_PINS];
        return (cur & ~clr_m) | set_m;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync
    import pinbank_pkg::*;
#(
    parameter int WIDTH  = NUM_PINS,
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pinbank_regs.sv
module pinbank_regs
    import pinbank_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    input  logic [BUS_W-1:0]      wdata,
    output logic [BUS_W-1:0]      rdata,
    input  logic [NUM_PINS-1:0]   level_in,
    output pin_cfg_t [NUM_PINS-1:0] cfg_o,
    output logic [NUM_PINS-1:0]   data_o
);

    logic [FIELD2_W-1:0] func_q;
    logic [NUM_PINS-1:0] style_q;
    logic [FIELD2_W-1:0] rate_q;
    logic [FIELD2_W-1:0] res_q;
    logic [NUM_PINS-1:0] data_q;
    logic [BUS_W-1:0]    sel_lo_q;
    logic [BUS_W-1:0]    sel_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            func_q   <= '0;
            style_q  <= '0;
            rate_q   <= '0;
            res_q    <= '0;
            data_q   <= '0;
            sel_lo_q <= '0;
            sel_hi_q <= '0;
        end else if (wr) begin
            case (addr)
                W_FUNC:   func_q   <= wdata[FIELD2_W-1:0];
                W_STYLE:  style_q  <= wdata[NUM_PINS-1:0];
                W_RATE:   rate_q   <= wdata[FIELD2_W-1:0];
                W_RES:    res_q    <= wdata[FIELD2_W-1:0];
                W_DATA:   data_q   <= wdata[NUM_PINS-1:0];
                W_SETCLR: data_q   <= apply_setclr(data_q, wdata);
                W_SEL_LO: sel_lo_q <= wdata;
                W_SEL_HI: sel_hi_q <= wdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            W_FUNC:   rdata[FIELD2_W-1:0] = func_q;
            W_STYLE:  rdata[NUM_PINS-1:0] = style_q;
            W_RATE:   rdata[FIELD2_W-1:0] = rate_q;
            W_RES:    rdata[FIELD2_W-1:0] = res_q;
            W_LEVEL:  rdata[NUM_PINS-1:0] = level_in;
            W_DATA:   rdata[NUM_PINS-1:0] = data_q;
            W_SEL_LO: rdata = sel_lo_q;
            W_SEL_HI: rdata = sel_hi_q;
            default:  rdata = '0;
        endcase
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_cfg
        always_comb begin
            cfg_o[p].fn         = pin_fn_e'(func_q[2*p +: 2]);
            cfg_o[p].open_drain = style_q[p];
            cfg_o[p].rate       = rate_q[2*p +: 2];
            cfg_o[p].res        = res_sel_e'(res_q[2*p +: 2]);
        end
        if (p < HALF_PINS) begin : g_lo
            assign cfg_o[p].lane_sel = sel_lo_q[SEL_W*p +: SEL_W];
        end else begin : g_hi
            assign cfg_o[p].lane_sel = sel_hi_q[SEL_W*(p-HALF_PINS) +: SEL_W];
        end
    end

    assign data_o = data_q;

endmodule

// File: rtl/pinbank_pin.sv
module pinbank_pin
    import pinbank_pkg::*;
(
    input  pin_cfg_t             cfg,
    input  logic                 data_bit,
    input  logic [NUM_LANES-1:0] lanes,
    output pad_drive_t           drive
);

    logic pin_val;
    logic active;
    logic not_analog;

    always_comb begin
        not_analog = (cfg.fn != FN_ANALOG);
        active     = fn_drives(cfg.fn);
        case (cfg.fn)
            FN_OUTPUT: pin_val = data_bit;
            FN_PERIPH: pin_val = lanes[cfg.lane_sel];
            default:   pin_val = 1'b0;
        endcase

        if (!active) begin
            drive.value  = 1'b0;
            drive.enable = 1'b0;
        end else if (cfg.open_drain) begin
            drive.value  = 1'b0;
            drive.enable = ~pin_val;
        end else begin
            drive.value  = pin_val;
            drive.enable = 1'b1;
        end

        drive.up   = not_analog && (cfg.res == RES_UP);
        drive.down = not_analog && (cfg.res == RES_DOWN);
    end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          reg_wr,
    input  logic [BUS_W-1:0]              reg_wdata,
    output logic [BUS_W-1:0]              reg_rdata,
    input  logic [NUM_PINS-1:0]           pad_in,
    input  logic [NUM_LANES*NUM_PINS-1:0] af_lanes,
    output logic [NUM_PINS-1:0]           pad_out,
    output logic [NUM_PINS-1:0]           pad_oe,
    output logic [NUM_PINS-1:0]           pad_pu,
    output logic [NUM_PINS-1:0]           pad_pd,
    output logic [FIELD2_W-1:0]           pad_speed
);

    pin_cfg_t [NUM_PINS-1:0] cfg;
    logic [NUM_PINS-1:0]     data_bits;
    logic [NUM_PINS-1:0]     synced;
    logic [NUM_PINS-1:0]     level_vis;
    logic [FIELD2_W-1:0]     fn_vec;
    logic [NUM_PINS-1:0]     style_vec;

    pinbank_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (synced)
    );

    pinbank_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .addr     (reg_addr),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .level_in (level_vis),
        .cfg_o    (cfg),
        .data_o   (data_bits)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic [NUM_LANES-1:0] pin_lanes;
        pad_drive_t           drv;

        for (genvar s = 0; s < NUM_LANES; s++) begin : g_lane
            assign pin_lanes[s] = af_lanes[s*NUM_PINS + p];
        end

        pinbank_pin u_pin (
            .cfg      (cfg[p]),
            .data_bit (data_bits[p]),
            .lanes    (pin_lanes),
            .drive    (drv)
        );

        assign pad_out[p]          = drv.value;
        assign pad_oe[p]           = drv.enable;
        assign pad_pu[p]           = drv.up;
        assign pad_pd[p]           = drv.down;
        assign pad_speed[2*p +: 2] = cfg[p].rate;
        assign fn_vec[2*p +: 2]    = cfg[p].fn;
        assign style_vec[p]        = cfg[p].open_drain;
        assign level_vis[p]        = synced[p] & (cfg[p].fn != FN_ANALOG);
    end

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
    import pinbank_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [ADDR_W-1:0]     reg_addr,
    input logic                  reg_wr,
    input logic [BUS_W-1:0]      reg_wdata,
    input logic [BUS_W-1:0]      reg_rdata,
    input logic [NUM_PINS-1:0]   pad_in,
    input logic [NUM_PINS-1:0]   pad_out,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS-1:0]   pad_pu,
    input logic [NUM_PINS-1:0]   pad_pd,
    input logic [FIELD2_W-1:0]   fn_vec,
    input logic [NUM_PINS-1:0]   style_vec,
    input logic [NUM_PINS-1:0]   data_bits,
    input logic [NUM_PINS-1:0]   level_vis
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R9
    setclr_update_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == W_SETCLR) |=>
        data_bits == ((($past(data_bits)) & ~($past(reg_wdata[31:16]))) | $past(reg_wdata[15:0])));

    // R8
    data_write_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == W_DATA) |=> data_bits == $past(reg_wdata[15:0]));

    // R11
    setclr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == W_SETCLR) |-> reg_rdata == '0);

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        // R5
        analog_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (fn_vec[2*p +: 2] == FN_ANALOG) |-> (!pad_oe[p] && !pad_pu[p] && !pad_pd[p] && !level_vis[p]));

        // R2
        input_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
            (fn_vec[2*p +: 2] == FN_INPUT) |-> !pad_oe[p]);

        // R3
        open_drain_low_chk: assert property (@(posedge clk) disable iff (rst)
            style_vec[p] |-> !pad_out[p]);

        // R6
        pull_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
            !(pad_pu[p] && pad_pd[p]));

        // R7
        level_delay_chk: assert property (@(posedge clk) disable iff (rst)
            (since_rst >= 2'd2 && fn_vec[2*p +: 2] != FN_ANALOG) |-> level_vis[p] == $past(pad_in[p], 2));
    end

endmodule

bind pinbank_ctrl pinbank_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .fn_vec    (fn_vec),
    .style_vec (style_vec),
    .data_bits (data_bits),
    .level_vis (level_vis)
);

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [3:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic [15:0]  pad_in = '0;
    logic [255:0] af_lanes = '0;
    logic [15:0]  pad_out, pad_oe, pad_pu, pad_pd;
    logic [31:0]  pad_speed;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pinbank_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pad_in    (pad_in),
        .af_lanes  (af_lanes),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd),
        .pad_speed (pad_speed)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        reg_wr = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        reg_wdata = d;
        reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        for (int a = 0; a < 16; a++) begin
            rd(a[3:0], v);
            check("R1 register zero after reset", v, 32'h0);
        end
        check("R1 oe after reset", {16'h0, pad_oe}, 32'h0);
        check("R1 pulls after reset", {pad_pu, pad_pd}, 32'h0);
    endtask

    task automatic t_output();
        logic [31:0] v;
        do_reset();
        wr(4'd0, 32'h0000_0040);
        wr(4'd5, 32'h0000_0008);
        check("R2 push-pull oe", {16'h0, pad_oe}, 32'h0000_0008);
        check("R2 push-pull value", {16'h0, pad_out}, 32'h0000_0008);
        rd(4'd5, v);
        check("R8 data readback", v, 32'h0000_0008);
        wr(4'd5, 32'hFFFF_0000);
        check("R8 data replaced", {16'h0, pad_out}, 32'h0);
        rd(4'd0, v);
        check("R2 function readback", v, 32'h0000_0040);
    endtask

    task automatic t_setclr();
        logic [31:0] v;
        do_reset();
        wr(4'd5, 32'h0000_00F0);
        wr(4'd6, 32'h0010_0003);
        rd(4'd5, v);
        check("R9 set and clear with others kept", v, 32'h0000_00E3);
        wr(4'd6, 32'h0100_0100);
        rd(4'd5, v);
        check("R10 set wins over clear", v, 32'h0000_01E3);
        wr(4'd6, 32'h0002_0000);
        rd(4'd5, v);
        check("R9 clear only", v, 32'h0000_01E1);
        rd(4'd6, v);
        check("R11 set/clear word reads zero", v, 32'h0);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd12, v);
        check("R11 unmapped reads zero", v, 32'h0);
        rd(4'd5, v);
        check("R11 unmapped write leaves data", v, 32'h0000_01E1);
        rd(4'd0, v);
        check("R11 unmapped write leaves function", v, 32'h0);
    endtask

    task automatic t_open_drain();
        do_reset();
        wr(4'd0, 32'h0000_0040);
        wr(4'd1, 32'h0000_0008);
        wr(4'd5, 32'h0000_0008);
        check("R3 open-drain high released oe", {16'h0, pad_oe}, 32'h0);
        check("R3 open-drain value low", {16'h0, pad_out}, 32'h0);
        wr(4'd5, 32'h0000_0000);
        check("R3 open-drain low drives oe", {16'h0, pad_oe}, 32'h0000_0008);
        check("R3 open-drain low value", {16'h0, pad_out}, 32'h0);
    endtask

    task automatic t_periph();
        do_reset();
        wr(4'd0, 32'h0020_0020);
        wr(4'd7, 32'h0000_0500);
        wr(4'd8, 32'h0000_0C00);
        af_lanes = '0;
        af_lanes[5*16+2] = 1'b1;
        #1;
        check("R4 low selector lane 5 pin 2", {16'h0, pad_out & 16'h0404}, 32'h0000_0004);
        check("R4 peripheral oe", {16'h0, pad_oe & 16'h0404}, 32'h0000_0404);
        af_lanes = '1;
        af_lanes[5*16+2] = 1'b0;
        af_lanes[12*16+10] = 1'b0;
        #1;
        check("R4 unselected lanes ignored", {16'h0, pad_out & 16'h0404}, 32'h0);
        af_lanes = '0;
        af_lanes[12*16+10] = 1'b1;
        #1;
        check("R4 high selector lane 12 pin 10", {16'h0, pad_out & 16'h0404}, 32'h0000_0400);
        af_lanes = '0;
    endtask

    task automatic t_pull();
        do_reset();
        wr(4'd3, 32'h0000_0039);
        check("R6 pull-up codes", {16'h0, pad_pu}, 32'h0000_0001);
        check("R6 pull-down code", {16'h0, pad_pd}, 32'h0000_0002);
    endtask

    task automatic t_analog();
        logic [31:0] v;
        do_reset();
        wr(4'd3, 32'h0000_0001);
        wr(4'd1, 32'h0000_0000);
        wr(4'd0, 32'h0000_0003);
        pad_in = 16'hFFFF;
        repeat (3) @(negedge clk);
        #1;
        check("R5 analog no pull", {16'h0, pad_pu}, 32'h0);
        check("R5 analog no drive", {16'h0, pad_oe}, 32'h0);
        rd(4'd4, v);
        check("R5 analog pin reads zero", v, 32'h0000_FFFE);
        pad_in = 16'h0000;
    endtask

    task automatic t_input();
        logic [31:0] v;
        do_reset();
        pad_in = 16'h0000;
        repeat (3) @(negedge clk);
        pad_in = 16'hA5A5;
        @(negedge clk);
        rd(4'd4, v);
        check("R7 level not visible after one edge", v, 32'h0);
        @(negedge clk);
        rd(4'd4, v);
        check("R7 level visible after two edges", v, 32'h0000_A5A5);
        pad_in = 16'h0000;
    endtask

    task automatic t_speed();
        logic [31:0] v;
        do_reset();
        wr(4'd2, 32'hC000_00E4);
        rd(4'd2, v);
        check("R12 rate readback", v, 32'hC000_00E4);
        check("R12 rate exported", pad_speed, 32'hC000_00E4);
        check("R12 rate has no drive effect", {16'h0, pad_oe}, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_output();
        t_setclr();
        t_open_drain();
        t_periph();
        t_pull();
        t_analog();
        t_input();
        t_speed();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule